// File: doc/BRIEF.md
# Double-Ranked Crossbar Connection Map

This block holds the routing configuration for a nonblocking crossbar and also implements the crossbar itself. It has 16 single-bit digital lanes in and 16 out. Each output selects any one input. Several outputs may select the same input, so one input can fan out to many outputs. Each output has an enable, and each input has a polarity-inversion bit that is applied before the crossbar.

Routing is held in two ranks. Register writes only ever land in a staging map, while the output multiplexers follow an active map. The active map takes a copy of the whole staging map when the `upd_strobe` input has a rising edge. That strobe may arrive asynchronously to `clk`. Because the copy is made in a single clock, every output switches to its new source in the same cycle.

Software reaches the block through a flat address/data port. The address is split into a 4-bit page and a 4-bit index. Writes are captured on the rising clock edge. Reads are combinational from the address.

Top module: `xbar_dualrank`

## Requirements
- R1: After a synchronous active-low reset, both the staging and the active map route output k from input k. All outputs are enabled and no input is inverted.
- R2: Output k carries the active map's chosen input for k, after that input's inversion bit is applied. Outputs choose independently, and one input may feed any number of outputs.
- R3: Writes to the staging map do not change the lane outputs or the active map until a transfer occurs. Page 1 (addresses 0x10..0x17) reads the active map and uses the same packing as page 0.
- R4: `upd_strobe` passes through a two-flop synchronizer, and a transfer happens only on a rising edge of the synchronized strobe. If the strobe rises before a clock edge, the active map changes on the third rising clock edge after it. Keeping the strobe high causes no further transfer.
- R5: Staging register 0x00+j (j = 0..7) holds the input select of output 2j in bits 3:0 and of output 2j+1 in bits 7:4. Reading it returns those staged values.
- R6: Address 0x20 holds the inversion bits of inputs 0..7 and address 0x21 those of inputs 8..15, with input n at bit n mod 8. A 1 inverts that input for every output that selects it.
- R7: Address 0x30 holds the enable bits of outputs 0..7 and address 0x31 those of outputs 8..15, with output n at bit n mod 8. A 1 enables the output, and a disabled output drives 0.
- R8: If a staging write lands on the same clock edge as a transfer, the active map receives the staging contents from before that write. The write still updates the staging map.
- R9: Writes to the active page or to unmapped addresses change nothing. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_strobe | input | 1 | Transfer request, asynchronous, acts on its rising edge |
| reg_wr_en | input | 1 | Register write enable |
| reg_addr | input | 8 | Register address: page in bits 7:4, index in bits 3:0 |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| lane_in | input | 16 | Input data lanes |
| lane_out | output | 16 | Output data lanes |

## Verification
A staging write and a map transfer can fall on the same clock edge. The bench provokes this by raising the strobe and counting two clock edges. It then holds a staging write so that it is captured on the third edge, which is the transfer edge. The result is judged by reading back both pages. The active page must show the staging value from before the write, and the staging page must show the new value. This is cross-checked by routing a lane pattern through the block and comparing the outputs with a bench model that applies the transfer before the write.

// File: rtl/xbar_pkg.sv
// Package: shared constants for the double-ranked crossbar.
// Assumes an 8-bit address split into a 4-bit page and a 4-bit index.
package xbar_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int PAGE_W = 4;

    // Register pages selected by the upper address bits.
    typedef enum logic [PAGE_W-1:0] {
        PG_STAGE  = 4'h0,
        PG_ACTIVE = 4'h1,
        PG_INV    = 4'h2,
        PG_EN     = 4'h3
    } page_e;
endpackage

// File: rtl/xbar_upd_sync.sv
// Module: synchronizes the transfer strobe and detects its rising edge.
// Assumes strobe pulses are held for at least SYNC_STAGES+1 clock cycles.
// Emits a single-cycle fire pulse SYNC_STAGES cycles after capture.
module xbar_upd_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_async,
    output logic fire
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [SYNC_STAGES:0] shift_q;

    // Shift the strobe through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[SYNC_STAGES-1:0], strobe_async};
        end
    end

    // Rising edge of the synchronized strobe.
    assign fire = shift_q[SYNC_STAGES-1] & ~shift_q[SYNC_STAGES];
endmodule

// File: rtl/xbar_cfg_regs.sv
// Module: configuration registers of the crossbar.
// Holds the staging map, active map, inversion mask and enable mask,
// and provides the combinational read mux.
// Assumes NUM_LANES is a multiple of DATA_W and SEL_W <= DATA_W/2.
module xbar_cfg_regs
    import xbar_pkg::*;
#(
    parameter int NUM_LANES = 16,
    parameter int SEL_W     = 4,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       xfer,
    output logic [DATA_W-1:0]          rdata,
    output logic [NUM_LANES*SEL_W-1:0] stage_flat,
    output logic [NUM_LANES*SEL_W-1:0] active_flat,
    output logic [NUM_LANES-1:0]       inv_bits,
    output logic [NUM_LANES-1:0]       out_en
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int IDX_W     = ADDR_W - PAGE_W;
    localparam int FIELD_W   = DATA_W / 2;
    localparam int MAP_REGS  = NUM_LANES / 2;
    localparam int MASK_REGS = NUM_LANES / DATA_W;

    logic [PAGE_W-1:0] page;
    logic [IDX_W-1:0]  idx;
    logic              stage_hit;
    logic              inv_hit;
    logic              en_hit;

    assign page      = addr[ADDR_W-1 -: PAGE_W];
    assign idx       = addr[IDX_W-1:0];
    assign stage_hit = wr_en && (page == PG_STAGE);
    assign inv_hit   = wr_en && (page == PG_INV);
    assign en_hit    = wr_en && (page == PG_EN);

    // Update both map ranks and the per-lane masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_LANES; k++) begin
                stage_flat[k*SEL_W +: SEL_W]  <= SEL_W'(k);
                active_flat[k*SEL_W +: SEL_W] <= SEL_W'(k);
            end
            inv_bits <= '0;
            out_en   <= '1;
        end else begin
            for (int k = 0; k < NUM_LANES; k++) begin
                if (stage_hit && idx == IDX_W'(k / 2)) begin
                    stage_flat[k*SEL_W +: SEL_W] <= wdata[(k % 2)*FIELD_W +: SEL_W];
                end
                if (xfer) begin
                    active_flat[k*SEL_W +: SEL_W] <= stage_flat[k*SEL_W +: SEL_W];
                end
                if (inv_hit && idx == IDX_W'(k / DATA_W)) begin
                    inv_bits[k] <= wdata[k % DATA_W];
                end
                if (en_hit && idx == IDX_W'(k / DATA_W)) begin
                    out_en[k] <= wdata[k % DATA_W];
                end
            end
        end
    end

    // Select read data by page and index; unmapped locations read 0.
    always_comb begin
        rdata = '0;
        case (page)
            PG_STAGE: begin
                for (int j = 0; j < MAP_REGS; j++) begin
                    if (idx == IDX_W'(j)) begin
                        rdata[SEL_W-1:0]           = stage_flat[(2*j)*SEL_W +: SEL_W];
                        rdata[FIELD_W +: SEL_W]    = stage_flat[(2*j+1)*SEL_W +: SEL_W];
                    end
                end
            end
            PG_ACTIVE: begin
                for (int j = 0; j < MAP_REGS; j++) begin
                    if (idx == IDX_W'(j)) begin
                        rdata[SEL_W-1:0]           = active_flat[(2*j)*SEL_W +: SEL_W];
                        rdata[FIELD_W +: SEL_W]    = active_flat[(2*j+1)*SEL_W +: SEL_W];
                    end
                end
            end
            PG_INV: begin
                for (int j = 0; j < MASK_REGS; j++) begin
                    if (idx == IDX_W'(j)) rdata = inv_bits[j*DATA_W +: DATA_W];
                end
            end
            PG_EN: begin
                for (int j = 0; j < MASK_REGS; j++) begin
                    if (idx == IDX_W'(j)) rdata = out_en[j*DATA_W +: DATA_W];
                end
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/xbar_route.sv
// Module: the data path of the crossbar.
// Applies per-input inversion, then one multiplexer per output driven by
// the active map, then the output enable gate. Purely combinational.
module xbar_route #(
    parameter int NUM_LANES = 16,
    parameter int SEL_W     = 4
) (
    input  logic [NUM_LANES-1:0]       lane_in,
    input  logic [NUM_LANES-1:0]       inv_bits,
    input  logic [NUM_LANES-1:0]       out_en,
    input  logic [NUM_LANES*SEL_W-1:0] active_flat,
    output logic [NUM_LANES-1:0]       lane_out
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [NUM_LANES-1:0] pol_in;

    // Polarity correction ahead of the switch matrix.
    assign pol_in = lane_in ^ inv_bits;

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_out
        logic [SEL_W-1:0] sel;
        assign sel = active_flat[k*SEL_W +: SEL_W];
        // Per-output multiplexer with enable gate.
        assign lane_out[k] = out_en[k] & pol_in[sel];
    end
endmodule

// File: rtl/xbar_dualrank.sv
// Module: top of the double-ranked crossbar connection map.
// Register writes fill a staging map; a synchronized rising edge on
// upd_strobe copies it into the active map that steers the lanes.
// Assumes an 8-bit register port and a lane count of 16 by default.
module xbar_dualrank #(
    parameter int NUM_LANES   = 16,
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd_strobe,
    input  logic                 reg_wr_en,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [NUM_LANES-1:0] lane_in,
    output logic [NUM_LANES-1:0] lane_out
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int SEL_W = $clog2(NUM_LANES);

    logic                       upd_fire;
    logic [NUM_LANES*SEL_W-1:0] stage_flat;
    logic [NUM_LANES*SEL_W-1:0] active_flat;
    logic [NUM_LANES-1:0]       inv_bits;
    logic [NUM_LANES-1:0]       out_en;

    xbar_upd_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) sync_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_async (upd_strobe),
        .fire         (upd_fire)
    );

    xbar_cfg_regs #(
        .NUM_LANES (NUM_LANES),
        .SEL_W     (SEL_W),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W)
    ) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr_en),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .xfer        (upd_fire),
        .rdata       (reg_rdata),
        .stage_flat  (stage_flat),
        .active_flat (active_flat),
        .inv_bits    (inv_bits),
        .out_en      (out_en)
    );

    xbar_route #(
        .NUM_LANES (NUM_LANES),
        .SEL_W     (SEL_W)
    ) route_i (
        .lane_in     (lane_in),
        .inv_bits    (inv_bits),
        .out_en      (out_en),
        .active_flat (active_flat),
        .lane_out    (lane_out)
    );
endmodule

// File: rtl/xbar_dualrank_chk.sv
// Checker: temporal properties of the crossbar configuration, bound to
// the top module. Observes the transfer pulse and both map ranks.
module xbar_dualrank_chk #(
    parameter int NUM_LANES = 16,
    parameter int SEL_W     = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       upd_fire,
    input logic [NUM_LANES*SEL_W-1:0] stage_flat,
    input logic [NUM_LANES*SEL_W-1:0] active_flat,
    input logic [NUM_LANES-1:0]       inv_bits,
    input logic [NUM_LANES-1:0]       out_en,
    input logic [NUM_LANES-1:0]       lane_out
);
    timeunit 1ns;
    timeprecision 100ps;

    function automatic logic [NUM_LANES*SEL_W-1:0] ident_map();
        logic [NUM_LANES*SEL_W-1:0] m;
        for (int k = 0; k < NUM_LANES; k++) m[k*SEL_W +: SEL_W] = SEL_W'(k);
        return m;
    endfunction

    AST_RESET_DEFAULTS: assert property (@(posedge clk)
        !rst_n |=> (active_flat == ident_map() && stage_flat == ident_map()
                    && out_en == '1 && inv_bits == '0)); // R1

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_fire |=> $stable(active_flat)); // R3

    AST_XFER_OLD_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_fire |=> active_flat == $past(stage_flat)); // R8

    AST_SINGLE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_fire |=> !upd_fire); // R4

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_dis
        AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            !out_en[k] |-> !lane_out[k]); // R7
    end
endmodule

bind xbar_dualrank xbar_dualrank_chk #(
    .NUM_LANES (NUM_LANES),
    .SEL_W     (SEL_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_fire    (upd_fire),
    .stage_flat  (stage_flat),
    .active_flat (active_flat),
    .inv_bits    (inv_bits),
    .out_en      (out_en),
    .lane_out    (lane_out)
);

// File: tb/xbar_dualrank_tb.sv
// Testbench: directed corner cases plus seeded random traffic, checked
// against a behavioural model of both map ranks and the lane masks.
module xbar_dualrank_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_strobe = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] lane_in = '0;
    logic [15:0] lane_out;

    int total = 0;
    int bad = 0;

    logic [3:0]  m_stage [16];
    logic [3:0]  m_act   [16];
    logic [15:0] m_inv;
    logic [15:0] m_en;

    always #2 clk = ~clk;

    xbar_dualrank dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_strobe (upd_strobe),
        .reg_wr_en  (reg_wr_en),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .lane_in    (lane_in),
        .lane_out   (lane_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        logic [3:0] pg = a[7:4];
        logic [3:0] ix = a[3:0];
        if (pg == 4'h0 && ix < 8) return {m_stage[2*ix+1], m_stage[2*ix]};
        if (pg == 4'h1 && ix < 8) return {m_act[2*ix+1], m_act[2*ix]};
        if (pg == 4'h2 && ix < 2) return m_inv[ix*8 +: 8];
        if (pg == 4'h3 && ix < 2) return m_en[ix*8 +: 8];
        return 8'h00;
    endfunction

    function automatic logic [15:0] exp_out(input logic [15:0] p);
        logic [15:0] o;
        for (int k = 0; k < 16; k++) o[k] = m_en[k] & (p[m_act[k]] ^ m_inv[m_act[k]]);
        return o;
    endfunction

    function automatic void model_wr(input logic [7:0] a, input logic [7:0] d);
        logic [3:0] pg = a[7:4];
        logic [3:0] ix = a[3:0];
        if (pg == 4'h0 && ix < 8) begin
            m_stage[2*ix]   = d[3:0];
            m_stage[2*ix+1] = d[7:4];
        end else if (pg == 4'h2 && ix < 2) begin
            m_inv[ix*8 +: 8] = d;
        end else if (pg == 4'h3 && ix < 2) begin
            m_en[ix*8 +: 8] = d;
        end
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        model_wr(a, d);
    endtask

    // Reads a range of registers inside one low clock phase.
    task automatic chk_regs(input string req, input logic [7:0] base, input int n);
        for (int j = 0; j < n; j++) begin
            reg_addr = base + 8'(j);
            #0.2;
            chk(req, 32'(reg_rdata), 32'(exp_rd(base + 8'(j))));
        end
    endtask

    task automatic chk_lanes(input string req, input logic [15:0] p);
        lane_in = p;
        #0.2;
        chk(req, 32'(lane_out), 32'(exp_out(p)));
    endtask

    task automatic do_update();
        @(negedge clk);
        upd_strobe = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk_regs("R4 active unchanged before third edge", 8'h10, 8);
        @(negedge clk);
        for (int k = 0; k < 16; k++) m_act[k] = m_stage[k];
        chk_regs("R4 active after third edge", 8'h10, 8);
        upd_strobe = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] old0;
        void'($urandom(32'd4711));
        for (int k = 0; k < 16; k++) begin m_stage[k] = 4'(k); m_act[k] = 4'(k); end
        m_inv = '0; m_en = '1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset contents and identity routing
        chk_regs("R1 staging reset", 8'h00, 8);
        chk_regs("R1 active reset", 8'h10, 8);
        chk_regs("R1 inversion reset", 8'h20, 2);
        chk_regs("R1 enable reset", 8'h30, 2);
        chk_lanes("R1 identity route", 16'hA5C3);
        chk_lanes("R1 identity route", 16'h0001);

        // R5 staging packing, R3 no effect before transfer, R2 fan-out
        for (int j = 0; j < 8; j++) wr(8'(j), 8'h55);
        chk_regs("R5 staging readback", 8'h00, 8);
        chk_regs("R3 active unchanged", 8'h10, 8);
        chk_lanes("R3 lanes unchanged", 16'h1234);
        do_update();
        chk_lanes("R2 fan-out of input 5", 16'h0020);
        chk_lanes("R2 fan-out of input 5", 16'hFFDF);

        // R4 strobe held high gives no second transfer
        @(negedge clk);
        upd_strobe = 1'b1;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 16; k++) m_act[k] = m_stage[k];
        wr(8'h00, 8'h3C);
        repeat (5) @(negedge clk);
        chk_regs("R4 held strobe no retransfer", 8'h10, 1);
        upd_strobe = 1'b0;
        repeat (3) @(negedge clk);
        do_update();

        // R5 distinct fields per output, R2 permutation
        for (int j = 0; j < 8; j++) wr(8'(j), {4'(15 - 2*j - 1), 4'(15 - 2*j)});
        chk_regs("R5 field packing", 8'h00, 8);
        do_update();
        chk_lanes("R2 reversed route", 16'h8001);
        chk_lanes("R2 reversed route", 16'h00F0);

        // R6 inversion on high and low inputs
        wr(8'h21, 8'h20);
        wr(8'h20, 8'h01);
        chk_regs("R6 inversion readback", 8'h20, 2);
        chk_lanes("R6 inverted inputs 0 and 13", 16'h0000);
        chk_lanes("R6 inverted inputs 0 and 13", 16'hFFFF);

        // R7 output disable
        wr(8'h30, 8'hF0);
        wr(8'h31, 8'h0F);
        chk_regs("R7 enable readback", 8'h30, 2);
        chk_lanes("R7 disabled outputs low", 16'hFFFF);
        chk_lanes("R7 disabled outputs low", 16'h5A5A);

        // R8 write on the transfer edge
        wr(8'h00, 8'h21);
        @(negedge clk);
        upd_strobe = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 8'h00; reg_wdata = 8'h9E;
        @(negedge clk);
        reg_wr_en = 1'b0;
        for (int k = 0; k < 16; k++) m_act[k] = m_stage[k];
        model_wr(8'h00, 8'h9E);
        chk_regs("R8 active takes pre-write staging", 8'h10, 1);
        chk_regs("R8 staging takes write", 8'h00, 1);
        chk_lanes("R8 route after collision", 16'h0006);
        upd_strobe = 1'b0;
        repeat (3) @(negedge clk);

        // R9 writes to active page and unmapped space ignored
        old0 = exp_rd(8'h10);
        wr(8'h10, ~old0);
        wr(8'h45, 8'hFF);
        wr(8'h08, 8'hFF);
        wr(8'h22, 8'hFF);
        @(negedge clk);
        chk_regs("R9 active page not writable", 8'h10, 8);
        chk_regs("R9 unmapped reads zero", 8'h45, 1);
        chk_regs("R9 unmapped reads zero", 8'h08, 1);
        chk_regs("R9 unmapped reads zero", 8'h22, 1);
        chk_regs("R9 masks untouched", 8'h20, 2);
        chk_lanes("R9 lanes untouched", 16'hC3A5);

        // Seeded random mix across R2 R3 R5 R6 R7
        for (int it = 0; it < 40; it++) begin
            int unsigned r = $urandom % 8;
            if (r < 5) wr(8'($urandom % 8), 8'($urandom));
            else if (r == 5) wr(8'h20 + 8'($urandom % 2), 8'($urandom));
            else if (r == 6) wr(8'h30 + 8'($urandom % 2), 8'($urandom));
            else do_update();
            @(negedge clk);
            chk_regs("R5 random staging readback", 8'h00, 8);
            @(negedge clk);
            chk_lanes("R2 random route", 16'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule